// File: doc/BRIEF.md
# Circular Self-Test Ring Register

This block is a bank of register cells that doubles as a built-in self-test structure. In functional operation every cell is an ordinary D flip-flop. It loads its bit of the data bus on each clock. When the test enable is raised, the cells join into a closed ring. Each cell then loads the XOR of its data bit with the present value of the cell before it, and the last cell feeds cell 0. The feedback polynomial is therefore x^N + 1.

The logic under test sits between the ring outputs and the data bus. Because of that, a single structure both produces the stimulus and compacts the response. No separate pattern generator or signature compactor is needed.

A run lasts a programmable number of test clocks. After that many ring updates the cells freeze, and a done flag marks the whole ring state as the signature. A synchronous active-low reset forces every cell to a known seed before a run. This keeps unknown values out of the signature and makes it repeatable.

Top module: `cstp_ring`

## Requirements
- R1: While rst_n is low at a clock edge, every cell takes its bit of the RESET_VAL parameter (default all zeros) and sig_done reads 0; no cell holds an unknown value afterwards.
- R2: With test_en low, on every clock edge ring_q takes the value of din unchanged.
- R3: With test_en high and the run not complete, on each clock edge cell i takes din[i] XOR ring_q[i-1] for i from 1 to N-1, and cell 0 takes din[0] XOR ring_q[N-1].
- R4: After test_en rises, exactly run_len ring updates occur; sig_done is 0 before the run_len-th update and 1 from then on while test_en stays high.
- R5: While test_en is high and sig_done is 1, ring_q does not change whatever din does.
- R6: If run_len is 0 when test_en rises, sig_done is 1 at once and ring_q keeps its value.
- R7: Lowering test_en drops sig_done in the same cycle, returns the cells to plain capture and restarts the count, so the next rise of test_en performs a fresh run of run_len updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset to the seed |
| test_en | input | 1 | 1 = ring self-test, 0 = plain register |
| run_len | input | LEN_W | Number of test clocks in one run; held steady during a run |
| din | input | N | Functional data bus, normally the logic-under-test response |
| ring_q | output | N | Cell states; the signature once sig_done is 1 |
| sig_done | output | 1 | Run finished, ring frozen |

## Verification
The bench closes the loop through a fixed combinational function of ring_q and compares the final state with a software model over runs of up to 1000 clocks. A wrong tap, such as cell 0 fed from cell 1 or an inverted XOR, would diverge within a few cycles. An off-by-one counter would show up at the check one cycle before completion, or in the signature itself. The bench also covers a zero-length run, which must neither move the ring nor withhold done. It checks that a frozen ring ignores din, and that dropping test_en mid-run really clears the count. A design that kept the old count would finish the following run early and leave a wrong signature.

// File: rtl/cstp_pkg.sv
// Shared types for the circular self-test ring.
package cstp_pkg;
    // Operating mode broadcast from the run controller to every cell.
    typedef enum logic [1:0] {
        RING_CAPTURE = 2'd0,  // plain D flip-flop
        RING_SHIFT   = 2'd1,  // XOR data with predecessor
        RING_FREEZE  = 2'd2   // keep state, signature ready
    } ring_mode_e;
endpackage

// File: rtl/cstp_cell.sv
// One self-test cell: a flip-flop that either captures its data bit,
// folds it with the predecessor's state, or holds.
// Assumes: mode is glitch-free (registered upstream state), sync reset.
module cstp_cell
    import cstp_pkg::*;
#(
    parameter logic SEED_BIT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ring_mode_e mode,
    input  logic       d,
    input  logic       prev_q,
    output logic       q
);
    // Cell state update per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED_BIT;
        end else begin
            unique case (mode)
                RING_CAPTURE: q <= d;
                RING_SHIFT:   q <= d ^ prev_q;
                default:      q <= q;
            endcase
        end
    end
endmodule

// File: rtl/cstp_run_ctrl.sv
// Run controller: counts test clocks while test_en is high and picks the
// ring mode. Assumes run_len stays constant for the duration of a run.
module cstp_run_ctrl
    import cstp_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic [LEN_W-1:0] run_len,
    output ring_mode_e       mode,
    output logic             done
);
    logic [LEN_W-1:0] steps_q;
    logic             reached;

    // Mode decode from enable and progress.
    always_comb begin
        reached = (steps_q == run_len);
        if (!test_en)     mode = RING_CAPTURE;
        else if (reached) mode = RING_FREEZE;
        else              mode = RING_SHIFT;
        done = test_en && reached;
    end

    // Step counter: cleared outside test, advances once per ring update.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_en) begin
            steps_q <= '0;
        end else if (!reached) begin
            steps_q <= steps_q + 1'b1;
        end
    end
endmodule

// File: rtl/cstp_ring.sv
// Circular self-test path register: N cells closed into a ring
// (polynomial x^N + 1) serving as both stimulus source and compactor.
// Assumes N >= 2 and a reset before every self-test run.
module cstp_ring
    import cstp_pkg::*;
#(
    parameter int         N         = 16,
    parameter int         LEN_W     = 16,
    parameter logic [N-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic [LEN_W-1:0] run_len,
    input  logic [N-1:0]     din,
    output logic [N-1:0]     ring_q,
    output logic             sig_done
);
    ring_mode_e   mode;
    logic [N-1:0] pred;

    cstp_run_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .test_en (test_en),
        .run_len (run_len),
        .mode    (mode),
        .done    (sig_done)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        // Ring link: cell 0 closes the loop from the last cell.
        if (i == 0) begin : g_head
            assign pred[i] = ring_q[N-1];
        end else begin : g_body
            assign pred[i] = ring_q[i-1];
        end

        cstp_cell #(.SEED_BIT(RESET_VAL[i])) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (mode),
            .d      (din[i]),
            .prev_q (pred[i]),
            .q      (ring_q[i])
        );
    end
endmodule

// File: rtl/cstp_ring_chk.sv
// Checker for cstp_ring, observing only its ports.
module cstp_ring_chk #(
    parameter int           N         = 16,
    parameter int           LEN_W     = 16,
    parameter logic [N-1:0] RESET_VAL = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_en,
    input logic [LEN_W-1:0] run_len,
    input logic [N-1:0]     din,
    input logic [N-1:0]     ring_q,
    input logic             sig_done
);
    p_seed_r1: assert property (@(posedge clk)
        !rst_n |=> (ring_q == RESET_VAL) && !sig_done);

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> ring_q == $past(din));

    p_ring_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !sig_done) |=>
            ring_q == ($past(din) ^ {$past(ring_q[N-2:0]), $past(ring_q[N-1])}));

    p_done_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sig_done |-> test_en);

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && sig_done) |=> $stable(ring_q));

    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && run_len == '0) |-> sig_done);

    p_done_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_done && test_en) |=> (sig_done || !test_en));

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> !sig_done);
endmodule

bind cstp_ring cstp_ring_chk #(.N(N), .LEN_W(LEN_W), .RESET_VAL(RESET_VAL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .run_len  (run_len),
    .din      (din),
    .ring_q   (ring_q),
    .sig_done (sig_done)
);

// File: tb/test_cstp_ring.sv
module test_cstp_ring;
    localparam int N = 16;
    localparam int LEN_W = 16;

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] key;
        logic [15:0] ext;
        logic        loop;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{len: 16'd1,    key: 16'h0000, ext: 16'h8001, loop: 1'b0},
        '{len: 16'd5,    key: 16'h0000, ext: 16'h1234, loop: 1'b0},
        '{len: 16'd17,   key: 16'hF00F, ext: 16'h0000, loop: 1'b1},
        '{len: 16'd64,   key: 16'h5A5A, ext: 16'h0000, loop: 1'b1},
        '{len: 16'd200,  key: 16'h0FF0, ext: 16'h0000, loop: 1'b1},
        '{len: 16'd1000, key: 16'hFFFF, ext: 16'h0000, loop: 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             test_en = 1'b0;
    logic [LEN_W-1:0] run_len = '0;
    logic [N-1:0]     din;
    logic [N-1:0]     ring_q;
    logic             sig_done;
    logic             cut_loop = 1'b0;
    logic [N-1:0]     cut_key = '0;
    logic [N-1:0]     ext_d = '0;
    int               errors = 0;
    int               checks = 0;
    bit               finished = 1'b0;

    always #2 clk = ~clk;

    // Fixed combinational stand-in for the logic under test.
    function automatic logic [N-1:0] cut_f(input logic [N-1:0] q, input logic [N-1:0] k);
        return {q[10:0], q[15:11]} ^ (q & k) ^ 16'h3C5A;
    endfunction

    // Requirement model of one ring update (R3).
    function automatic logic [N-1:0] ring_step(input logic [N-1:0] q, input logic [N-1:0] d);
        return d ^ {q[N-2:0], q[N-1]};
    endfunction

    assign din = cut_loop ? cut_f(ring_q, cut_key) : ext_d;

    cstp_ring #(.N(N), .LEN_W(LEN_W)) i_cstp_ring (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .run_len(run_len),
        .din(din), .ring_q(ring_q), .sig_done(sig_done)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        test_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [N-1:0] exp;
        logic [N-1:0] held;
        @(negedge clk);
        do_reset();
        // R1: seed and no unknowns
        check("R1 seed", ring_q, '0);
        check("R1 done low", {15'd0, sig_done}, '0);
        check("R1 no X", {15'd0, $isunknown(ring_q)}, '0);

        // Table walk: R3/R4 signature and count, R5 freeze
        foreach (VEC[v]) begin
            do_reset();
            cut_loop = VEC[v].loop;
            cut_key = VEC[v].key;
            ext_d = VEC[v].ext;
            exp = '0;
            for (int s = 0; s < int'(VEC[v].len); s++)
                exp = ring_step(exp, VEC[v].loop ? cut_f(exp, VEC[v].key) : VEC[v].ext);
            run_len = VEC[v].len;
            test_en = 1'b1;
            repeat (int'(VEC[v].len) - 1) @(negedge clk);
            check("R4 done early", {15'd0, sig_done}, '0);
            @(negedge clk);
            check("R4 done", {15'd0, sig_done}, 16'd1);
            check("R3 signature", ring_q, exp);
            cut_loop = 1'b0;
            ext_d = 16'hBEEF;
            repeat (3) @(negedge clk);
            check("R5 frozen", ring_q, exp);
            test_en = 1'b0;
        end

        // R2: plain capture
        do_reset();
        cut_loop = 1'b0;
        ext_d = 16'hC0DE;
        @(negedge clk);
        check("R2 capture", ring_q, 16'hC0DE);
        ext_d = 16'h1357;
        @(negedge clk);
        check("R2 capture 2", ring_q, 16'h1357);

        // R6: zero-length run
        run_len = '0;
        test_en = 1'b1;
        #1;
        check("R6 done at once", {15'd0, sig_done}, 16'd1);
        ext_d = 16'hFFFF;
        repeat (2) @(negedge clk);
        check("R6 no update", ring_q, 16'h1357);

        // R7: abort mid-run, then a fresh run
        test_en = 1'b0;
        #1;
        check("R7 done drops", {15'd0, sig_done}, '0);
        ext_d = 16'h0F0F;
        @(negedge clk);
        run_len = 16'd4;
        ext_d = 16'h0001;
        test_en = 1'b1;
        repeat (2) @(negedge clk);
        test_en = 1'b0;
        ext_d = 16'hA000;
        @(negedge clk);
        check("R7 capture after abort", ring_q, 16'hA000);
        held = 16'hA000;
        ext_d = 16'h0003;
        test_en = 1'b1;
        for (int s = 0; s < 4; s++) held = ring_step(held, 16'h0003);
        repeat (3) @(negedge clk);
        check("R7 fresh count", {15'd0, sig_done}, '0);
        @(negedge clk);
        check("R7 full run", ring_q, held);
        check("R7 done", {15'd0, sig_done}, 16'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule